// File: doc/BRIEF.md
# Wavefront Lane Permute Unit

This block redistributes per-lane operand data across a 64-lane wavefront in the stage before an ALU. The lanes form four rows of 16 lanes. Across the rows they also form four banks, and each bank holds four consecutive lanes of every row. A 4-bit permute code selects one of twelve exchange patterns. The patterns are quad-local permutes, mirrors, row-local shifts and rotates, single-lane shifts and rotates across the whole wave, and two row broadcasts. A shift amount and a quad selector field supply the pattern parameters.

Every destination lane resolves to a source lane. If that source lies outside the row or wave boundary, or if its per-lane enable is low, the source is invalid. Without the zero-fill option, a lane with an invalid source keeps its old destination value. With the option, it receives zero. The row mask and the bank mask gate which destination lanes may be written at all. The result and a per-lane write-enable are registered, so they appear one clock after the inputs.

Top module: `lane_xchg`

## Requirements
- R1: Code 0 (quad permute): lane i reads lane 4*(i/4)+q, where q is the 2-bit field sel_i[2k+1:2k] and k = i%4.
- R2: Code 1 reverses each 16-lane row, so lane j of a row reads lane 15-j. Code 2 reverses each 8-lane half of a row.
- R3: Codes 3, 4 and 5 stay inside the row. In each, j is the lane's position in its row and n is amt_i. Code 3 reads lane j+n and is invalid when j+n > 15. Code 4 reads lane j-n and is invalid when j < n. Code 5 reads lane (j-n) mod 16. An amount of 0 makes every lane read itself.
- R4: Codes 6 to 9 move data by one lane across the whole wave. Code 6 reads lane i+1 and is invalid at lane 63. Code 7 reads lane (i+1) mod 64. Code 8 reads lane i-1 and is invalid at lane 0. Code 9 reads lane (i+63) mod 64.
- R5: Code 10 sends lane 15 of each row to every lane of the next row, and row 0 has no source. Code 11 sends lane 31 to every lane of rows 2 and 3, and rows 0 and 1 have no source.
- R6: A source lane whose lane_en_i bit is low is invalid, exactly as a source past a boundary is.
- R7: A lane with an invalid source is handled by zero_fill_i. With zero_fill_i=0 it outputs its old_i value with write-enable 0. With zero_fill_i=1 it outputs zero with write-enable 1.
- R8: Lane i belongs to row i/16 and bank (i%16)/4. If row_mask_i[row] or bank_mask_i[bank] is 0, the lane outputs its old_i value with write-enable 0, whatever its source.
- R9: Outputs are registered and reflect the inputs of the previous clock edge. During reset, data_o and we_o are all zero.
- R10: Codes 12 to 15 make every lane read itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64*DW | Source data, lane i at bits [i*DW +: DW] |
| old_i | input | 64*DW | Previous destination data per lane |
| lane_en_i | input | 64 | Per-lane source enable |
| mode_i | input | 4 | Permute code |
| amt_i | input | 4 | Row shift or rotate amount |
| sel_i | input | 8 | Quad permute selectors |
| row_mask_i | input | 4 | Row write enables |
| bank_mask_i | input | 4 | Bank write enables |
| zero_fill_i | input | 1 | Invalid sources give zero |
| data_o | output | 64*DW | Registered result per lane |
| we_o | output | 64 | Registered per-lane write-enable |

## Verification
Each code is first driven with distinct random lane data and all masks open, so a wrong source index shows up as a wrong value in a named lane. Shift amounts 1, 15 and 0 are then tried at the row edges, where out-of-range lanes must keep their old data or be zeroed. Partial row and bank masks and sparse lane enables separate the masking path from the invalid-source path. Long random sequences then mix all codes, including the reserved ones, against a behavioural model.

// File: rtl/lx_pkg.sv
package lx_pkg;
  localparam logic [3:0] PM_QUAD        = 4'd0;
  localparam logic [3:0] PM_MIRROR      = 4'd1;
  localparam logic [3:0] PM_HALF_MIRROR = 4'd2;
  localparam logic [3:0] PM_ROW_SHL     = 4'd3;
  localparam logic [3:0] PM_ROW_SHR     = 4'd4;
  localparam logic [3:0] PM_ROW_ROR     = 4'd5;
  localparam logic [3:0] PM_WAVE_SHL    = 4'd6;
  localparam logic [3:0] PM_WAVE_ROL    = 4'd7;
  localparam logic [3:0] PM_WAVE_SHR    = 4'd8;
  localparam logic [3:0] PM_WAVE_ROR    = 4'd9;
  localparam logic [3:0] PM_BCAST_ROW   = 4'd10;
  localparam logic [3:0] PM_BCAST_HALF  = 4'd11;
  localparam int QUAD = 4;
  localparam int BANKS = 4;
endpackage

// File: rtl/lx_src_sel.sv
module lx_src_sel
  import lx_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  localparam int IDX_W = $clog2(LANES),
  localparam int SH_W  = $clog2(ROW_LANES)
) (
  input  logic [3:0]             mode_i,
  input  logic [SH_W-1:0]        amt_i,
  input  logic [2*QUAD-1:0]      sel_i,
  output logic [LANES*IDX_W-1:0] idx_o,
  output logic [LANES-1:0]       ok_o
);
  localparam int HALF = ROW_LANES / 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int R  = g / ROW_LANES;
    localparam int J  = g % ROW_LANES;
    localparam int RB = R * ROW_LANES;
    int   s;
    logic v;
    always_comb begin
      s = g;
      v = 1'b1;
      case (mode_i)
        PM_QUAD:        s = (g / QUAD) * QUAD + int'(sel_i[2*(g%QUAD) +: 2]);
        PM_MIRROR:      s = RB + ROW_LANES - 1 - J;
        PM_HALF_MIRROR: s = (J < HALF) ? RB + HALF - 1 - J : RB + ROW_LANES - 1 - (J - HALF);
        PM_ROW_SHL: begin s = g + int'(amt_i); v = (J + int'(amt_i)) < ROW_LANES; end
        PM_ROW_SHR: begin s = g - int'(amt_i); v = J >= int'(amt_i); end
        PM_ROW_ROR:     s = RB + ((J - int'(amt_i) + ROW_LANES) % ROW_LANES);
        PM_WAVE_SHL: begin s = g + 1; v = (g != LANES - 1); end
        PM_WAVE_ROL:    s = (g + 1) % LANES;
        PM_WAVE_SHR: begin s = g - 1; v = (g != 0); end
        PM_WAVE_ROR:    s = (g + LANES - 1) % LANES;
        PM_BCAST_ROW: begin s = RB - 1; v = (R != 0); end
        PM_BCAST_HALF: begin s = 2 * ROW_LANES - 1; v = (R >= 2); end
        default: ;
      endcase
      // row-local codes never leave their row (R2, R3)
      if (v && (mode_i == PM_MIRROR || mode_i == PM_HALF_MIRROR || mode_i == PM_ROW_SHL ||
                mode_i == PM_ROW_SHR || mode_i == PM_ROW_ROR))
        a_r3_row_local: assert (s / ROW_LANES == R);
    end
    assign idx_o[g*IDX_W +: IDX_W] = v ? IDX_W'(s) : IDX_W'(g);
    assign ok_o[g] = v;
  end
endmodule

// File: rtl/lx_lane_mux.sv
module lx_lane_mux
  import lx_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int DW        = 32,
  localparam int IDX_W = $clog2(LANES),
  localparam int ROWS  = LANES / ROW_LANES,
  localparam int BANK_LANES = ROW_LANES / BANKS
) (
  input  logic [LANES*DW-1:0]    src_i,
  input  logic [LANES*DW-1:0]    old_i,
  input  logic [LANES-1:0]       lane_en_i,
  input  logic [LANES*IDX_W-1:0] idx_i,
  input  logic [LANES-1:0]       ok_i,
  input  logic [ROWS-1:0]        row_mask_i,
  input  logic [BANKS-1:0]       bank_mask_i,
  input  logic                   zero_fill_i,
  output logic [LANES*DW-1:0]    data_o,
  output logic [LANES-1:0]       we_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int R  = g / ROW_LANES;
    localparam int BK = (g % ROW_LANES) / BANK_LANES;
    logic [IDX_W-1:0] sidx;
    logic act, live;
    assign sidx = idx_i[g*IDX_W +: IDX_W];
    assign act  = row_mask_i[R] & bank_mask_i[BK];
    assign live = ok_i[g] & lane_en_i[sidx];
    always_comb begin
      if (!act) begin
        data_o[g*DW +: DW] = old_i[g*DW +: DW];
        we_o[g] = 1'b0;
      end else if (live) begin
        data_o[g*DW +: DW] = src_i[int'(sidx)*DW +: DW];
        we_o[g] = 1'b1;
      end else if (zero_fill_i) begin
        data_o[g*DW +: DW] = '0;
        we_o[g] = 1'b1;
      end else begin
        data_o[g*DW +: DW] = old_i[g*DW +: DW];
        we_o[g] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lane_xchg.sv
module lane_xchg
  import lx_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int DW        = 32,
  localparam int IDX_W = $clog2(LANES),
  localparam int SH_W  = $clog2(ROW_LANES),
  localparam int ROWS  = LANES / ROW_LANES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES*DW-1:0] src_i,
  input  logic [LANES*DW-1:0] old_i,
  input  logic [LANES-1:0]    lane_en_i,
  input  logic [3:0]          mode_i,
  input  logic [SH_W-1:0]     amt_i,
  input  logic [2*QUAD-1:0]   sel_i,
  input  logic [ROWS-1:0]     row_mask_i,
  input  logic [BANKS-1:0]    bank_mask_i,
  input  logic                zero_fill_i,
  output logic [LANES*DW-1:0] data_o,
  output logic [LANES-1:0]    we_o
);
  logic [LANES*IDX_W-1:0] idx;
  logic [LANES-1:0]       ok;
  logic [LANES*DW-1:0]    nxt_data;
  logic [LANES-1:0]       nxt_we;

  lx_src_sel #(.LANES(LANES), .ROW_LANES(ROW_LANES)) u_sel (
    .mode_i(mode_i), .amt_i(amt_i), .sel_i(sel_i), .idx_o(idx), .ok_o(ok)
  );

  lx_lane_mux #(.LANES(LANES), .ROW_LANES(ROW_LANES), .DW(DW)) u_mux (
    .src_i(src_i), .old_i(old_i), .lane_en_i(lane_en_i), .idx_i(idx), .ok_i(ok),
    .row_mask_i(row_mask_i), .bank_mask_i(bank_mask_i), .zero_fill_i(zero_fill_i),
    .data_o(nxt_data), .we_o(nxt_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      we_o   <= '0;
    end else begin
      data_o <= nxt_data;
      we_o   <= nxt_we;
    end
  end

  a_r8_rows_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_mask_i == '0) |=> (we_o == '0 && data_o == $past(old_i)));

  a_r8_banks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_mask_i == '0) |=> (we_o == '0));

  a_r7_edge_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PM_WAVE_SHL && zero_fill_i && row_mask_i[ROWS-1] && bank_mask_i[BANKS-1])
    |=> (we_o[LANES-1] && data_o[LANES*DW-1 -: DW] == '0));

  a_r4_first_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PM_WAVE_SHR && !zero_fill_i && row_mask_i[0] && bank_mask_i[0])
    |=> (!we_o[0] && data_o[DW-1:0] == $past(old_i[DW-1:0])));
endmodule

// File: tb/tb_lane_xchg.sv
module tb_lane_xchg;
  localparam int L  = 64;
  localparam int DW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [L*DW-1:0] src_i = '0, old_i = '0;
  logic [L-1:0] lane_en_i = '1;
  logic [3:0] mode_i = '0, amt_i = '0;
  logic [7:0] sel_i = 8'he4;
  logic [3:0] row_mask_i = '1, bank_mask_i = '1;
  logic zero_fill_i = 1'b0;
  logic [L*DW-1:0] data_o;
  logic [L-1:0] we_o;

  int checks = 0;
  int errors = 0;
  logic [L*DW-1:0] exp_d;
  logic [L-1:0] exp_we;

  always #5 clk_i = ~clk_i;

  lane_xchg dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .old_i(old_i), .lane_en_i(lane_en_i),
    .mode_i(mode_i), .amt_i(amt_i), .sel_i(sel_i), .row_mask_i(row_mask_i),
    .bank_mask_i(bank_mask_i), .zero_fill_i(zero_fill_i), .data_o(data_o), .we_o(we_o)
  );

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4, 4'd5: return "R3";
      4'd6, 4'd7, 4'd8, 4'd9: return "R4";
      4'd10, 4'd11: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic model();
    for (int i = 0; i < L; i++) begin
      int r = i / 16;
      int j = i % 16;
      int n = int'(amt_i);
      int s = i;
      bit ok = 1'b1;
      case (mode_i)
        4'd0: s = (i / 4) * 4 + int'(sel_i[2*(i%4) +: 2]);
        4'd1: s = r * 16 + 15 - j;
        4'd2: s = r * 16 + ((j < 8) ? 7 - j : 23 - j);
        4'd3: if (j + n > 15) ok = 0; else s = i + n;
        4'd4: if (j < n) ok = 0; else s = i - n;
        4'd5: s = r * 16 + (j - n + 16) % 16;
        4'd6: if (i == 63) ok = 0; else s = i + 1;
        4'd7: s = (i + 1) % 64;
        4'd8: if (i == 0) ok = 0; else s = i - 1;
        4'd9: s = (i + 63) % 64;
        4'd10: if (r == 0) ok = 0; else s = r * 16 - 1;
        4'd11: if (r < 2) ok = 0; else s = 31;
        default: s = i;
      endcase
      if (ok && !lane_en_i[s]) ok = 0;  // R6
      if (!(row_mask_i[r] && bank_mask_i[j/4])) begin  // R8
        exp_d[i*DW +: DW] = old_i[i*DW +: DW];
        exp_we[i] = 1'b0;
      end else if (ok) begin
        exp_d[i*DW +: DW] = src_i[s*DW +: DW];
        exp_we[i] = 1'b1;
      end else if (zero_fill_i) begin  // R7
        exp_d[i*DW +: DW] = '0;
        exp_we[i] = 1'b1;
      end else begin
        exp_d[i*DW +: DW] = old_i[i*DW +: DW];
        exp_we[i] = 1'b0;
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    for (int i = 0; i < L; i++) begin
      if (data_o[i*DW +: DW] !== exp_d[i*DW +: DW] || we_o[i] !== exp_we[i]) begin
        errors++;
        $display("FAIL %s mode %0d lane %0d: actual data %h we %b, expected data %h we %b",
                 tag, mode_i, i, data_o[i*DW +: DW], we_o[i], exp_d[i*DW +: DW], exp_we[i]);
        break;
      end
    end
  endtask

  // inputs are set at a negedge; result is compared at the following negedge (R9)
  task automatic step(input string tag);
    model();
    @(posedge clk_i);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic new_data();
    for (int i = 0; i < L; i++) begin
      src_i[i*DW +: DW] = $urandom();
      old_i[i*DW +: DW] = $urandom();
    end
  endtask

  task automatic open_all();
    lane_en_i = '1; row_mask_i = '1; bank_mask_i = '1; zero_fill_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    new_data();
    repeat (3) @(negedge clk_i);
    checks++;  // R9 reset state
    if (data_o !== '0 || we_o !== '0) begin
      errors++;
      $display("FAIL R9 reset: actual we %h, expected 0", we_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // every code with open masks (R1..R5, R10)
    for (int m = 0; m < 16; m++) begin
      open_all(); new_data();
      mode_i = 4'(m); amt_i = 4'd5; sel_i = 8'h1b;
      step(tag_of(mode_i));
    end
    // boundary amounts (R3)
    foreach (amt_i[k]) begin end
    for (int m = 3; m <= 5; m++) begin
      mode_i = 4'(m);
      amt_i = 4'd1;  new_data(); step("R3");
      amt_i = 4'd15; new_data(); step("R3");
      amt_i = 4'd0;  new_data(); step("R3");
      zero_fill_i = 1'b1; amt_i = 4'd15; step("R7");
      zero_fill_i = 1'b0;
    end
    // wave edges with zero fill (R4, R7)
    for (int m = 6; m <= 9; m++) begin
      mode_i = 4'(m); zero_fill_i = 1'b1; new_data(); step("R7");
      zero_fill_i = 1'b0; step("R4");
    end
    // broadcasts with sparse enables (R5, R6)
    mode_i = 4'd10; lane_en_i = 64'h0000_8000_0000_8000; step("R6");
    mode_i = 4'd11; lane_en_i = 64'hFFFF_FFFF_7FFF_FFFF; step("R6");
    zero_fill_i = 1'b1; step("R7");
    // masks (R8)
    open_all(); mode_i = 4'd1;
    row_mask_i = 4'b1010; step("R8");
    row_mask_i = 4'b1111; bank_mask_i = 4'b0011; step("R8");
    row_mask_i = 4'b0000; step("R8");
    row_mask_i = 4'b0110; bank_mask_i = 4'b0000; zero_fill_i = 1'b1; step("R8");
    // random mix
    for (int t = 0; t < 400; t++) begin
      new_data();
      mode_i = 4'($urandom_range(0, 15));
      amt_i = 4'($urandom());
      sel_i = 8'($urandom());
      lane_en_i = {$urandom(), $urandom()} | {$urandom(), $urandom()};
      row_mask_i = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hF;
      bank_mask_i = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hF;
      zero_fill_i = 1'($urandom());
      step(tag_of(mode_i));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule